// File: doc/BRIEF.md
# Integer ALU with Instruction Decode

This block takes one 32-bit RISC instruction word together with the two register operands already read for it. It decodes the word as register-register (R), immediate (I) or jump (J) format. It then performs the integer arithmetic, logic, shift, compare or load-upper operation and returns a registered result one clock later. Along with the result it gives the destination register number, a write-enable for the register file, a signed-overflow trap flag and a flag for instructions it does not execute.

Register-file reads, multiply/divide, branches, jumps and memory accesses are handled elsewhere. For those, the block only extracts the fields: the two source register numbers and the 26-bit jump immediate. `op_a` carries the value of the register named by bits [25:21] (rs). `op_b` carries the value of the register named by bits [20:16] (rt). The register file is expected to discard writes to register 0.

Top module: `alu_decode_unit`

## Requirements
- R1: One clock edge after `in_valid` is sampled high, `out_valid` is high. `src_a_idx` = instr[25:21], `src_b_idx` = instr[20:16] and `jump_imm` = instr[25:0] of that instruction.
- R2: The destination is instr[15:11] when the opcode instr[31:26] is 0x00 (R format), and instr[20:16] for the immediate opcodes.
- R3: add (funct 0x20), sub (funct 0x22) and addi (opcode 0x08) raise `ovf_trap` on two's-complement overflow. addu (0x21), subu (0x23) and addiu (opcode 0x09) wrap modulo 2^32 and never raise it.
- R4: When `ovf_trap` is raised, `wr_en` is low.
- R5: The 16-bit immediate instr[15:0] is sign-extended for addi, addiu and slti (opcode 0x0A). It is zero-extended for andi (0x0C), ori (0x0D), xori (0x0E) and sltiu (0x0B).
- R6: The funct codes 0x24, 0x25, 0x26 and 0x27 give `op_a` AND, OR, XOR and NOR `op_b`.
- R7: sll (0x00), srl (0x02) and sra (0x03) shift `op_b` by instr[10:6]. sllv (0x04), srlv (0x06) and srav (0x07) shift `op_b` by `op_a`[4:0] only.
- R8: sra and srav fill vacated bits with `op_b`[31]. All other shifts fill with zeros.
- R9: slt (0x2A) and slti compare signed; sltu (0x2B) and sltiu compare unsigned. The result is 1 when `op_a` is below the second operand, else 0.
- R10: lui (opcode 0x0F) gives the immediate in bits [31:16] and zeros in bits [15:0], with `op_a` ignored.
- R11: Any other opcode or funct sets `unsupported` and leaves `wr_en` and `ovf_trap` low.
- R12: A cycle with `in_valid` low gives, one edge later, `out_valid`, `wr_en`, `ovf_trap` and `unsupported` all low.
- R13: While `rst` is high at a clock edge, every output becomes zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and operands are valid this cycle |
| instr | input | 32 | Instruction word |
| op_a | input | DATA_W | Value of the rs register |
| op_b | input | DATA_W | Value of the rt register |
| out_valid | output | 1 | Registered outputs belong to an issued instruction |
| result | output | DATA_W | Operation result |
| dest_idx | output | 5 | Destination register number |
| wr_en | output | 1 | Write the result to the destination |
| ovf_trap | output | 1 | Signed overflow exception |
| unsupported | output | 1 | Instruction not executed by this block |
| src_a_idx | output | 5 | rs field |
| src_b_idx | output | 5 | rt field |
| jump_imm | output | 26 | 26-bit jump immediate field |

## Verification
The bench builds the block with the default DATA_W of 32, which matches the instruction formats. At that width the exact overflow boundaries are reachable: 0x7FFFFFFF + 1 and 0x80000000 - 1. So are shift counts of 31 with sign fill, and immediates whose bit 15 separates sign from zero extension. The vectors sit on those edges, and each mnemonic is paired with its trapping or wrapping twin so the two can be told apart.

// File: rtl/alu_dec_pkg.sv
package alu_dec_pkg;

  localparam int INSTR_W = 32;
  localparam int RIDX_W  = 5;
  localparam int IMM_W   = 16;
  localparam int JIMM_W  = 26;

  // primary opcodes
  localparam logic [5:0] OPC_RTYPE = 6'h00;
  localparam logic [5:0] OPC_ADDI  = 6'h08;
  localparam logic [5:0] OPC_ADDIU = 6'h09;
  localparam logic [5:0] OPC_SLTI  = 6'h0A;
  localparam logic [5:0] OPC_SLTIU = 6'h0B;
  localparam logic [5:0] OPC_ANDI  = 6'h0C;
  localparam logic [5:0] OPC_ORI   = 6'h0D;
  localparam logic [5:0] OPC_XORI  = 6'h0E;
  localparam logic [5:0] OPC_LUI   = 6'h0F;

  // function codes of the register format
  localparam logic [5:0] FN_SLL  = 6'h00;
  localparam logic [5:0] FN_SRL  = 6'h02;
  localparam logic [5:0] FN_SRA  = 6'h03;
  localparam logic [5:0] FN_SLLV = 6'h04;
  localparam logic [5:0] FN_SRLV = 6'h06;
  localparam logic [5:0] FN_SRAV = 6'h07;
  localparam logic [5:0] FN_ADD  = 6'h20;
  localparam logic [5:0] FN_ADDU = 6'h21;
  localparam logic [5:0] FN_SUB  = 6'h22;
  localparam logic [5:0] FN_SUBU = 6'h23;
  localparam logic [5:0] FN_AND  = 6'h24;
  localparam logic [5:0] FN_OR   = 6'h25;
  localparam logic [5:0] FN_XOR  = 6'h26;
  localparam logic [5:0] FN_NOR  = 6'h27;
  localparam logic [5:0] FN_SLT  = 6'h2A;
  localparam logic [5:0] FN_SLTU = 6'h2B;

  typedef enum logic [3:0] {
    OP_NONE, OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_NOR,
    OP_SLL, OP_SRL, OP_SRA, OP_SLT, OP_SLTU, OP_LUI
  } alu_op_e;

  typedef struct packed {
    alu_op_e            op;
    logic               legal;     // executed by this block
    logic               use_imm;   // second operand from immediate
    logic               imm_sext;  // sign-extend the immediate
    logic               var_shift; // shift count from op_a
    logic               trap_en;   // signed overflow raises a trap
    logic [RIDX_W-1:0]  dest;
    logic [4:0]         shamt;
    logic [IMM_W-1:0]   imm;
  } alu_ctl_t;

endpackage

// File: rtl/alu_field_decoder.sv
module alu_field_decoder
  import alu_dec_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output alu_ctl_t           ctl,
  output logic [RIDX_W-1:0]  rs_f,
  output logic [RIDX_W-1:0]  rt_f,
  output logic [JIMM_W-1:0]  jimm_f
);

  logic [5:0] opc;
  logic [5:0] fn;

  assign opc    = instr[31:26];
  assign fn     = instr[5:0];
  assign rs_f   = instr[25:21];
  assign rt_f   = instr[20:16];
  assign jimm_f = instr[25:0];

  always_comb begin
    ctl           = '0;
    ctl.op        = OP_NONE;
    ctl.shamt     = instr[10:6];
    ctl.imm       = instr[15:0];
    ctl.dest      = (opc == OPC_RTYPE) ? instr[15:11] : instr[20:16];
    if (opc == OPC_RTYPE) begin
      ctl.legal = 1'b1;
      case (fn)
        FN_ADD:  begin ctl.op = OP_ADD; ctl.trap_en = 1'b1; end
        FN_ADDU: ctl.op = OP_ADD;
        FN_SUB:  begin ctl.op = OP_SUB; ctl.trap_en = 1'b1; end
        FN_SUBU: ctl.op = OP_SUB;
        FN_AND:  ctl.op = OP_AND;
        FN_OR:   ctl.op = OP_OR;
        FN_XOR:  ctl.op = OP_XOR;
        FN_NOR:  ctl.op = OP_NOR;
        FN_SLT:  ctl.op = OP_SLT;
        FN_SLTU: ctl.op = OP_SLTU;
        FN_SLL:  ctl.op = OP_SLL;
        FN_SRL:  ctl.op = OP_SRL;
        FN_SRA:  ctl.op = OP_SRA;
        FN_SLLV: begin ctl.op = OP_SLL; ctl.var_shift = 1'b1; end
        FN_SRLV: begin ctl.op = OP_SRL; ctl.var_shift = 1'b1; end
        FN_SRAV: begin ctl.op = OP_SRA; ctl.var_shift = 1'b1; end
        default: ctl.legal = 1'b0;
      endcase
    end else begin
      ctl.legal   = 1'b1;
      ctl.use_imm = 1'b1;
      case (opc)
        OPC_ADDI:  begin ctl.op = OP_ADD; ctl.imm_sext = 1'b1; ctl.trap_en = 1'b1; end
        OPC_ADDIU: begin ctl.op = OP_ADD; ctl.imm_sext = 1'b1; end
        OPC_SLTI:  begin ctl.op = OP_SLT; ctl.imm_sext = 1'b1; end
        OPC_SLTIU: ctl.op = OP_SLTU;
        OPC_ANDI:  ctl.op = OP_AND;
        OPC_ORI:   ctl.op = OP_OR;
        OPC_XORI:  ctl.op = OP_XOR;
        OPC_LUI:   ctl.op = OP_LUI;
        default:   begin ctl.legal = 1'b0; ctl.use_imm = 1'b0; end
      endcase
    end
  end

endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int DATA_W = 32,
  localparam int SHW   = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] din,
  input  logic [SHW-1:0]    amt,
  input  logic              left,
  input  logic              arith,
  output logic [DATA_W-1:0] dout
);

  logic              fill;
  logic [DATA_W-1:0] stg [SHW+1];

  assign fill   = arith & din[DATA_W-1];
  assign stg[0] = din;

  // logarithmic stages: stage s moves by 2**s when amt[s] is set
  for (genvar s = 0; s < SHW; s++) begin : g_stage
    localparam int STEP = 1 << s;
    assign stg[s+1] = !amt[s] ? stg[s] :
                      left    ? {stg[s][DATA_W-1-STEP:0], {STEP{1'b0}}} :
                                {{STEP{fill}}, stg[s][DATA_W-1:STEP]};
  end

  assign dout = stg[SHW];

endmodule

// File: rtl/alu_exec.sv
module alu_exec
  import alu_dec_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int SHW   = $clog2(DATA_W)
) (
  input  alu_ctl_t          ctl,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  output logic [DATA_W-1:0] res,
  output logic              ovf
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] imm_ext;
  logic [DATA_W-1:0] opnd_b;
  logic [DATA_W-1:0] b_eff;
  logic              subtract;
  logic [DATA_W:0]   sum;
  logic              ovf_raw;
  logic              lt_s;
  logic              lt_u;
  logic [SHW-1:0]    sh_amt;
  logic [DATA_W-1:0] sh_out;

  assign imm_ext  = ctl.imm_sext ? {{(DATA_W-IMM_W){ctl.imm[IMM_W-1]}}, ctl.imm}
                                 : {{(DATA_W-IMM_W){1'b0}}, ctl.imm};
  assign opnd_b   = ctl.use_imm ? imm_ext : op_b;
  assign subtract = (ctl.op == OP_SUB) || (ctl.op == OP_SLT) || (ctl.op == OP_SLTU);
  assign b_eff    = subtract ? ~opnd_b : opnd_b;

  // one adder serves add, subtract and both compares
  assign sum      = {1'b0, op_a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, subtract};
  assign ovf_raw  = (op_a[MSB] == b_eff[MSB]) && (sum[MSB] != op_a[MSB]);
  assign lt_s     = sum[MSB] ^ ovf_raw;
  assign lt_u     = ~sum[DATA_W];
  assign ovf      = ctl.trap_en & ovf_raw;

  assign sh_amt   = ctl.var_shift ? op_a[SHW-1:0] : SHW'(ctl.shamt);

  alu_shifter #(.DATA_W(DATA_W)) u_shift (
    .din   (op_b),
    .amt   (sh_amt),
    .left  (ctl.op == OP_SLL),
    .arith (ctl.op == OP_SRA),
    .dout  (sh_out)
  );

  always_comb begin
    case (ctl.op)
      OP_ADD, OP_SUB: res = sum[DATA_W-1:0];
      OP_AND:         res = op_a & opnd_b;
      OP_OR:          res = op_a | opnd_b;
      OP_XOR:         res = op_a ^ opnd_b;
      OP_NOR:         res = ~(op_a | opnd_b);
      OP_SLL, OP_SRL, OP_SRA: res = sh_out;
      OP_SLT:         res = {{(DATA_W-1){1'b0}}, lt_s};
      OP_SLTU:        res = {{(DATA_W-1){1'b0}}, lt_u};
      OP_LUI:         res = {ctl.imm, {(DATA_W-IMM_W){1'b0}}};
      default:        res = '0;
    endcase
  end

endmodule

// File: rtl/alu_decode_unit.sv
module alu_decode_unit
  import alu_dec_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [INSTR_W-1:0]  instr,
  input  logic [DATA_W-1:0]   op_a,
  input  logic [DATA_W-1:0]   op_b,
  output logic                out_valid,
  output logic [DATA_W-1:0]   result,
  output logic [RIDX_W-1:0]   dest_idx,
  output logic                wr_en,
  output logic                ovf_trap,
  output logic                unsupported,
  output logic [RIDX_W-1:0]   src_a_idx,
  output logic [RIDX_W-1:0]   src_b_idx,
  output logic [JIMM_W-1:0]   jump_imm
);

  alu_ctl_t          ctl;
  logic [RIDX_W-1:0] rs_f;
  logic [RIDX_W-1:0] rt_f;
  logic [JIMM_W-1:0] jimm_f;
  logic [DATA_W-1:0] res_c;
  logic              ovf_c;

  alu_field_decoder u_dec (
    .instr  (instr),
    .ctl    (ctl),
    .rs_f   (rs_f),
    .rt_f   (rt_f),
    .jimm_f (jimm_f)
  );

  alu_exec #(.DATA_W(DATA_W)) u_exec (
    .ctl  (ctl),
    .op_a (op_a),
    .op_b (op_b),
    .res  (res_c),
    .ovf  (ovf_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      result      <= '0;
      dest_idx    <= '0;
      wr_en       <= 1'b0;
      ovf_trap    <= 1'b0;
      unsupported <= 1'b0;
      src_a_idx   <= '0;
      src_b_idx   <= '0;
      jump_imm    <= '0;
    end else begin
      out_valid   <= in_valid;
      wr_en       <= in_valid & ctl.legal & ~ovf_c;
      ovf_trap    <= in_valid & ctl.legal & ovf_c;
      unsupported <= in_valid & ~ctl.legal;
      if (in_valid) begin
        result    <= res_c;
        dest_idx  <= ctl.dest;
        src_a_idx <= rs_f;
        src_b_idx <= rt_f;
        jump_imm  <= jimm_f;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid && !wr_en && !ovf_trap && !unsupported); // R12
  AST_TRAP_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (rst)
    ovf_trap |-> !wr_en); // R4
  AST_UNSUP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    unsupported |-> !wr_en && !ovf_trap); // R11
  AST_WRAP_NO_TRAP: assert property (@(posedge clk) disable iff (rst)
    in_valid && (instr[31:26] == OPC_ADDIU ||
                 (instr[31:26] == OPC_RTYPE && (instr[5:0] == FN_ADDU || instr[5:0] == FN_SUBU)))
    |=> !ovf_trap); // R3
  AST_LUI_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
    in_valid && instr[31:26] == OPC_LUI |=> result[15:0] == '0); // R10
  AST_SLT_IS_BIT: assert property (@(posedge clk) disable iff (rst)
    in_valid && instr[31:26] == OPC_RTYPE && (instr[5:0] == FN_SLT || instr[5:0] == FN_SLTU)
    |=> result[DATA_W-1:1] == '0); // R9

endmodule

// File: tb/test_alu_decode_unit.sv
module test_alu_decode_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic        out_valid, wr_en, ovf_trap, unsupported;
  logic [31:0] result;
  logic [4:0]  dest_idx, src_a_idx, src_b_idx;
  logic [25:0] jump_imm;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk; // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  alu_decode_unit i_alu_decode_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr), .op_a(op_a), .op_b(op_b),
    .out_valid(out_valid), .result(result), .dest_idx(dest_idx), .wr_en(wr_en),
    .ovf_trap(ovf_trap), .unsupported(unsupported), .src_a_idx(src_a_idx),
    .src_b_idx(src_b_idx), .jump_imm(jump_imm)
  );

  typedef struct {
    int          at;
    bit          vld, we, ovf, uns;
    logic [31:0] res;
    logic [4:0]  dst, rs, rt;
    logic [25:0] jim;
    string       req;
  } exp_t;

  exp_t sb[$];

  function automatic logic [31:0] rfmt(logic [5:0] fn, logic [4:0] rs, logic [4:0] rt,
                                       logic [4:0] rd, logic [4:0] sh);
    return {6'h00, rs, rt, rd, sh, fn};
  endfunction

  function automatic logic [31:0] ifmt(logic [5:0] opc, logic [4:0] rs, logic [4:0] rt,
                                       logic [15:0] imm);
    return {opc, rs, rt, imm};
  endfunction

  // reference model written from the requirements
  function automatic exp_t model(logic [31:0] ins, logic [31:0] a, logic [31:0] b);
    exp_t e;
    longint sa, sb2, wide;
    logic [5:0]  opc = ins[31:26];
    logic [5:0]  fn  = ins[5:0];
    logic [31:0] se  = {{16{ins[15]}}, ins[15:0]};
    logic [31:0] ze  = {16'h0, ins[15:0]};
    e.vld = 1; e.we = 1; e.ovf = 0; e.uns = 0; e.res = '0;
    e.rs = ins[25:21]; e.rt = ins[20:16]; e.jim = ins[25:0];
    e.dst = (opc == 6'h00) ? ins[15:11] : ins[20:16];
    sa = longint'($signed(a));
    if (opc == 6'h00) begin
      sb2 = longint'($signed(b));
      case (fn)
        6'h20: begin wide = sa + sb2; e.res = a + b; e.ovf = (wide > 64'sd2147483647) || (wide < -64'sd2147483648); end
        6'h21: e.res = a + b;
        6'h22: begin wide = sa - sb2; e.res = a - b; e.ovf = (wide > 64'sd2147483647) || (wide < -64'sd2147483648); end
        6'h23: e.res = a - b;
        6'h24: e.res = a & b;
        6'h25: e.res = a | b;
        6'h26: e.res = a ^ b;
        6'h27: e.res = ~(a | b);
        6'h2A: e.res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
        6'h2B: e.res = (a < b) ? 32'd1 : 32'd0;
        6'h00: e.res = b << ins[10:6];
        6'h02: e.res = b >> ins[10:6];
        6'h03: e.res = $unsigned($signed(b) >>> ins[10:6]);
        6'h04: e.res = b << a[4:0];
        6'h06: e.res = b >> a[4:0];
        6'h07: e.res = $unsigned($signed(b) >>> a[4:0]);
        default: begin e.uns = 1; e.we = 0; end
      endcase
    end else begin
      case (opc)
        6'h08: begin wide = sa + longint'($signed(se)); e.res = a + se; e.ovf = (wide > 64'sd2147483647) || (wide < -64'sd2147483648); end
        6'h09: e.res = a + se;
        6'h0A: e.res = ($signed(a) < $signed(se)) ? 32'd1 : 32'd0;
        6'h0B: e.res = (a < ze) ? 32'd1 : 32'd0;
        6'h0C: e.res = a & ze;
        6'h0D: e.res = a | ze;
        6'h0E: e.res = a ^ ze;
        6'h0F: e.res = {ins[15:0], 16'h0};
        default: begin e.uns = 1; e.we = 0; end
      endcase
    end
    if (e.ovf) e.we = 0;
    return e;
  endfunction

  task automatic issue(logic [31:0] ins, logic [31:0] a, logic [31:0] b, string req);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1; instr = ins; op_a = a; op_b = b;
    e = model(ins, a, b);
    e.at = cyc; e.req = req;
    sb.push_back(e);
  endtask

  task automatic idle(string req);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b0; instr = 32'hFFFF_FFFF; op_a = 32'hDEAD_BEEF; op_b = 32'h1234_5678;
    e.at = cyc; e.req = req; e.vld = 0; e.we = 0; e.ovf = 0; e.uns = 0;
    e.res = '0; e.dst = '0; e.rs = '0; e.rt = '0; e.jim = '0;
    sb.push_back(e);
  endtask

  // monitor: compares each item one edge after it was driven
  always @(negedge clk) begin
    if (!rst && sb.size() > 0 && sb[0].at == cyc - 1) begin
      exp_t e;
      bit bad;
      e = sb.pop_front();
      bad = (out_valid != e.vld) || (wr_en != e.we) || (ovf_trap != e.ovf) || (unsupported != e.uns);
      if (e.vld) bad = bad || src_a_idx != e.rs || src_b_idx != e.rt || jump_imm != e.jim;
      if (e.vld && !e.uns) bad = bad || dest_idx != e.dst;
      if (e.we) bad = bad || result != e.res;
      n_checks++;
      if (bad) begin
        n_fail++;
        $display("FAIL %s: got v=%0b we=%0b ovf=%0b uns=%0b res=%h dst=%0d rs=%0d rt=%0d j=%h, expected v=%0b we=%0b ovf=%0b uns=%0b res=%h dst=%0d rs=%0d rt=%0d j=%h",
                 e.req, out_valid, wr_en, ovf_trap, unsupported, result, dest_idx, src_a_idx,
                 src_b_idx, jump_imm, e.vld, e.we, e.ovf, e.uns, e.res, e.dst, e.rs, e.rt, e.jim);
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    n_checks++; // R13 reset state
    if (out_valid || wr_en || ovf_trap || unsupported || result != 0 || dest_idx != 0 ||
        src_a_idx != 0 || src_b_idx != 0 || jump_imm != 0) begin
      n_fail++;
      $display("FAIL R13: got v=%0b we=%0b res=%h, expected all zero", out_valid, wr_en, result);
    end
    rst = 1'b0;

    issue(rfmt(6'h20, 5'd1, 5'd2, 5'd3, 5'd0), 32'd5, 32'd7, "R3 add");
    issue(rfmt(6'h20, 5'd4, 5'd5, 5'd6, 5'd0), 32'h7FFF_FFFF, 32'd1, "R4 add overflow");
    issue(rfmt(6'h21, 5'd4, 5'd5, 5'd6, 5'd0), 32'h7FFF_FFFF, 32'd1, "R3 addu wraps");
    issue(rfmt(6'h22, 5'd7, 5'd8, 5'd9, 5'd0), 32'h8000_0000, 32'd1, "R4 sub overflow");
    issue(rfmt(6'h23, 5'd7, 5'd8, 5'd9, 5'd0), 32'h8000_0000, 32'd1, "R3 subu wraps");
    issue(rfmt(6'h22, 5'd7, 5'd8, 5'd10, 5'd0), 32'd10, 32'd3, "R3 sub");
    issue(ifmt(6'h08, 5'd2, 5'd11, 16'hFFFF), 32'hFFFF_FFFB, 32'h5555_5555, "R2 R5 addi sign");
    issue(ifmt(6'h08, 5'd2, 5'd11, 16'h0001), 32'h7FFF_FFFF, 32'h0, "R4 addi overflow");
    issue(ifmt(6'h09, 5'd2, 5'd12, 16'h8000), 32'h7FFF_FFFF, 32'h0, "R5 addiu sign, no trap");
    issue(ifmt(6'h0C, 5'd3, 5'd13, 16'h8001), 32'hFFFF_FFFF, 32'h0, "R5 andi zero ext");
    issue(ifmt(6'h0D, 5'd3, 5'd14, 16'hF000), 32'h0000_0001, 32'h0, "R5 ori zero ext");
    issue(ifmt(6'h0E, 5'd3, 5'd15, 16'hFFFF), 32'hFFFF_0F0F, 32'h0, "R5 xori zero ext");
    issue(ifmt(6'h0B, 5'd3, 5'd16, 16'hFFFF), 32'd5, 32'h0, "R9 sltiu zero ext");
    issue(ifmt(6'h0A, 5'd3, 5'd17, 16'hFFFF), 32'd5, 32'h0, "R9 slti signed");
    issue(rfmt(6'h2A, 5'd1, 5'd2, 5'd18, 5'd0), 32'hFFFF_FFFF, 32'd1, "R9 slt");
    issue(rfmt(6'h2B, 5'd1, 5'd2, 5'd18, 5'd0), 32'hFFFF_FFFF, 32'd1, "R9 sltu");
    issue(rfmt(6'h24, 5'd1, 5'd2, 5'd19, 5'd0), 32'hF0F0_1234, 32'h0FF0_FF00, "R6 and");
    issue(rfmt(6'h25, 5'd1, 5'd2, 5'd19, 5'd0), 32'hF0F0_1234, 32'h0FF0_FF00, "R6 or");
    issue(rfmt(6'h26, 5'd1, 5'd2, 5'd19, 5'd0), 32'hF0F0_1234, 32'h0FF0_FF00, "R6 xor");
    issue(rfmt(6'h27, 5'd1, 5'd2, 5'd19, 5'd0), 32'hF0F0_1234, 32'h0FF0_FF00, "R6 nor");
    issue(rfmt(6'h00, 5'd0, 5'd2, 5'd20, 5'd4), 32'hFFFF_FFFF, 32'h8765_4321, "R7 sll");
    issue(rfmt(6'h02, 5'd0, 5'd2, 5'd20, 5'd31), 32'h0, 32'h8000_0000, "R7 R8 srl");
    issue(rfmt(6'h03, 5'd0, 5'd2, 5'd21, 5'd4), 32'h0, 32'h8000_0000, "R8 sra");
    issue(rfmt(6'h04, 5'd1, 5'd2, 5'd22, 5'd9), 32'h0000_0023, 32'h0000_0011, "R7 sllv low bits");
    issue(rfmt(6'h06, 5'd1, 5'd2, 5'd22, 5'd0), 32'hFFFF_FFE1, 32'hF000_0000, "R7 R8 srlv");
    issue(rfmt(6'h07, 5'd1, 5'd2, 5'd23, 5'd0), 32'h0000_001F, 32'h8000_0000, "R8 srav");
    issue(ifmt(6'h0F, 5'd9, 5'd24, 16'hABCD), 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R10 lui");
    idle("R12 idle");
    issue(ifmt(6'h23, 5'd5, 5'd6, 16'h0010), 32'h1, 32'h2, "R11 load opcode");
    issue(rfmt(6'h18, 5'd1, 5'd2, 5'd0, 5'd0), 32'h3, 32'h4, "R11 multiply funct");
    issue({6'h02, 26'h2AB_CDEF}, 32'h0, 32'h0, "R1 R11 jump field");
    idle("R12 idle after unsupported");
    issue(rfmt(6'h20, 5'd31, 5'd30, 5'd29, 5'd0), 32'h8000_0000, 32'h8000_0000, "R4 add negative overflow");
    issue(rfmt(6'h21, 5'd0, 5'd0, 5'd0, 5'd0), 32'h1, 32'h2, "R1 R2 dest zero");
    idle("R12 idle");
    repeat (3) @(negedge clk);
    done = 1'b1;
    if (sb.size() != 0) begin
      n_checks++; n_fail++;
      $display("FAIL R1: %0d results never seen, expected 0", sb.size());
    end
    summary();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run hung, got no end, expected end");
      summary();
    end
  end

endmodule